// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block sequences one channel of a memory-to-memory DMA engine through two descriptor chains held in memory. One chain describes the source buffers and the other the destination buffers. Both chains hold the same number of descriptors and are walked in step, one pair at a time. For each pair the walker reads the source descriptor and then the destination descriptor over a 64-bit memory read port. It issues one data-mover request that carries both address/length pairs, and waits for the mover's acknowledge before it goes on to the next pair.

A chain is either a packed array of 16-byte descriptors or a linked list of 32-byte descriptors, each of which carries the address of its successor. The layout and the transfer mode are sampled when the channel is started. Only the normal read-then-write mode is accepted, and any other mode is refused with an error flag. A descriptor can request a pause: the channel parks after that pair's transfer and waits for an explicit resume. The last descriptor ends the walk with a one-cycle done pulse, and the enable bit clears itself at that point.

Top module: `sgw_walker`

## Requirements
- R1: After a synchronous active-low reset, state is idle (0), chan_en, done, mode_err, fetch_req and mv_req are all 0.
- R2: A start pulse while idle with mode 0 (normal) sets chan_en, moves state to busy (2), loads cur_src_dscr/cur_dst_dscr from src_base/dst_base, and latches layout_linked for the whole walk.
- R3: Linear layout (layout_linked=0): a descriptor occupies 16 bytes and is read as two 64-bit words at offsets 0 and 8. Word 0 is the buffer address; word 1 holds the byte count in bits 31:0 and the control word in bits 63:32. The next descriptor lies 16 bytes further on.
- R4: Linked layout (layout_linked=1): a descriptor is read as three words at offsets 0, 8 and 16, with the same first two words as R3. The word at offset 16 is the address of the next descriptor. The reserved word at offset 24 is never read.
- R5: For each pair, the source descriptor is read before the destination descriptor. Then exactly one mover request presents both buffer addresses and both byte counts, and is held stable until mv_ack.
- R6: A pair whose source and destination byte counts are both zero issues no mover request, and the walk continues with the next pair.
- R7: Control bit 0 (last) in either descriptor of a pair ends the walk after that pair. done pulses for exactly one cycle, chan_en clears and state returns to idle.
- R8: Control bit 1 (pause) in either descriptor of a non-last pair moves state to paused (1) after that pair. While paused, no fetch or mover request is made. A resume pulse returns the channel to busy, and it continues with the following pair. On the last pair, last takes precedence over pause.
- R9: state takes only the encodings 0 idle, 1 paused and 2 busy, and chan_en is 1 exactly when state is not idle.
- R10: A start while idle with mode 1 (read-only), 2 (write-only) or 3 is refused. mode_err goes to 1, the channel stays idle and nothing is fetched. The next accepted start clears mode_err.
- R11: A start while busy or paused, and a resume while not paused, have no effect on the walk or on the descriptor pointers.
- R12: cur_src_dscr/cur_dst_dscr hold the addresses of the pair being processed and advance to the next pair after each non-last pair. While paused, they show the pair that resume will fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Channel enable pulse |
| resume | input | 1 | Leave the paused state |
| mode | input | 2 | Transfer mode, 0 normal, 1 read-only, 2 write-only |
| layout_linked | input | 1 | 0 linear chains, 1 linked-list chains |
| src_base | input | 64 | First source descriptor address |
| dst_base | input | 64 | First destination descriptor address |
| fetch_req | output | 1 | Descriptor word read request |
| fetch_addr | output | 64 | Byte address of the word being read |
| fetch_ack | input | 1 | Read completes, fetch_data valid |
| fetch_data | input | 64 | Read data |
| mv_req | output | 1 | Data-mover request |
| mv_src_addr | output | 64 | Source buffer address |
| mv_src_len | output | 32 | Source byte count |
| mv_dst_addr | output | 64 | Destination buffer address |
| mv_dst_len | output | 32 | Destination byte count |
| mv_ack | input | 1 | Mover has finished the request |
| chan_en | output | 1 | Channel enable, self-clearing |
| state | output | 2 | 0 idle, 1 paused, 2 busy |
| done | output | 1 | One-cycle pulse at the end of the walk |
| mode_err | output | 1 | Last start was refused for its mode |
| cur_src_dscr | output | 64 | Current source descriptor address |
| cur_dst_dscr | output | 64 | Current destination descriptor address |

## Verification
Chains are built from random buffer addresses, random byte counts with a quarter of them zero, and random noise in the unused control bits. Linked chains are laid out in a scrambled order, so that a walker which strides by 16 instead of following the next pointer reads the wrong words. A logged sequence of read addresses separates the two- and three-word layouts and shows that the reserved word is never touched. Directed chains cover a single pair, a chain of only empty pairs, a pause on every pair, and an end marker carried only by the destination side. These show the skip rule, parking and resuming, and the rule that either side can end the walk. Refused modes, starts during a walk and resumes while idle are checked for having no effect on the outputs or on the read and mover logs.

// File: rtl/sgw_pkg.sv
// Package: shared constants and types for the scatter-gather descriptor walker.
// Assumes 64-bit descriptor words and 8-byte aligned descriptor addresses.
package sgw_pkg;

    localparam int ADDR_W      = 64;
    localparam int LEN_W       = 32;
    localparam int WORD_W      = 64;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int LIN_WORDS   = 2;
    localparam int LNK_WORDS   = 3;
    localparam int IDX_W       = $clog2(LNK_WORDS + 1);
    localparam int LIN_STRIDE  = LIN_WORDS * WORD_BYTES;
    localparam int CTRL_LAST   = 0;
    localparam int CTRL_PAUSE  = 1;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_PAUSED = 2'd1,
        CH_BUSY   = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_RD_ONLY = 2'd1,
        MODE_WR_ONLY = 2'd2
    } xfer_mode_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_GO_SRC,
        W_WAIT_SRC,
        W_GO_DST,
        W_WAIT_DST,
        W_ISSUE,
        W_DECIDE,
        W_PAUSED
    } walk_e;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic [LEN_W-1:0]  size;
        logic              last;
        logic              pause;
        logic [ADDR_W-1:0] next;
    } dscr_t;

endpackage

// File: rtl/sgw_fetch.sv
// Module: sgw_fetch
// Reads one descriptor as consecutive 64-bit words starting at a base address
// and decodes it. Two words are read in linear layout and three in linked layout,
// so the reserved word is skipped. Assumes the memory holds fetch_data valid in the
// cycle fetch_ack is high, and that go only arrives while the fetcher is not active.
module sgw_fetch
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic              linked,
    output logic              done,
    output dscr_t             dscr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data
);

    logic              active;
    logic              linked_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    dscr_t             dscr_q;
    logic              done_q;
    logic              unused_ctrl_bits;

    // Index of the final word for the latched layout.
    assign last_idx = linked_q ? IDX_W'(LNK_WORDS - 1) : IDX_W'(LIN_WORDS - 1);

    // Word address: base plus eight bytes per word already read.
    assign rd_addr = base_q + ADDR_W'(idx) * ADDR_W'(WORD_BYTES);
    assign rd_req  = active;
    assign done    = done_q;
    assign dscr    = dscr_q;

    // Control bits other than last and pause carry no meaning.
    assign unused_ctrl_bits = ^rd_data[WORD_W-1:LEN_W+2];

    // Word sequencing and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            linked_q <= 1'b0;
            base_q   <= '0;
            idx      <= '0;
            dscr_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !active) begin
                active   <= 1'b1;
                linked_q <= linked;
                base_q   <= base;
                idx      <= '0;
            end else if (active && rd_ack) begin
                case (idx)
                    IDX_W'(0): dscr_q.buf_addr <= rd_data[ADDR_W-1:0];
                    IDX_W'(1): begin
                        dscr_q.size  <= rd_data[LEN_W-1:0];
                        dscr_q.last  <= rd_data[LEN_W + CTRL_LAST];
                        dscr_q.pause <= rd_data[LEN_W + CTRL_PAUSE];
                    end
                    default:   dscr_q.next <= rd_data[ADDR_W-1:0];
                endcase
                if (idx == last_idx) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    // A pending read keeps its address until acknowledged (R3, R4).
    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // A linked descriptor never reaches the reserved word (R4).
    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((rd_addr - base_q) < ADDR_W'(LNK_WORDS * WORD_BYTES)));

endmodule

// File: rtl/sgw_nextptr.sv
// Module: sgw_nextptr
// Works out the address of the following descriptor in a chain: a fixed stride
// past the current descriptor for linear layout, or the stored next pointer for
// linked layout. Purely combinational.
module sgw_nextptr
    import sgw_pkg::*;
(
    input  logic              linked,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] link_field,
    output logic [ADDR_W-1:0] nxt
);

    // Select the successor address for the layout in use.
    always_comb begin
        if (linked) nxt = link_field;
        else        nxt = cur + ADDR_W'(LIN_STRIDE);
    end

endmodule

// File: rtl/sgw_seq.sv
// Module: sgw_seq
// Channel sequencer. It starts the channel, fetches the source and then the
// destination descriptor of each pair, issues or skips the mover request, and
// then ends, parks or advances. Assumes the fetcher returns one decoded descriptor
// per go and that successor addresses come from outside.
module sgw_seq
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic [1:0]        mode,
    input  logic              layout_linked,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_base,
    input  logic              fetch_done,
    input  dscr_t             fetch_dscr,
    output logic              mv_req,
    input  logic              mv_ack,
    output dscr_t             src_d,
    output dscr_t             dst_d,
    input  logic [ADDR_W-1:0] nxt_src,
    input  logic [ADDR_W-1:0] nxt_dst,
    output logic              linked_q,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              chan_en,
    output logic [1:0]        state,
    output logic              done,
    output logic              mode_err
);

    walk_e ws;
    logic  last_any;
    logic  pause_any;
    logic  both_empty;

    // Pair-level decisions: either side can end or park the walk.
    assign last_any   = src_d.last  | dst_d.last;
    assign pause_any  = src_d.pause | dst_d.pause;
    assign both_empty = (fetch_dscr.size == '0) && (src_d.size == '0);

    // Fetch launch and mover request decode.
    assign fetch_go   = (ws == W_GO_SRC) || (ws == W_GO_DST);
    assign fetch_base = (ws == W_GO_DST) ? cur_dst : cur_src;
    assign mv_req     = (ws == W_ISSUE);

    // Reported channel state.
    always_comb begin
        case (ws)
            W_IDLE:   state = CH_IDLE;
            W_PAUSED: state = CH_PAUSED;
            default:  state = CH_BUSY;
        endcase
    end

    // Walk state machine with pointer, enable and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws       <= W_IDLE;
            cur_src  <= '0;
            cur_dst  <= '0;
            chan_en  <= 1'b0;
            done     <= 1'b0;
            mode_err <= 1'b0;
            linked_q <= 1'b0;
            src_d    <= '0;
            dst_d    <= '0;
        end else begin
            done <= 1'b0;
            case (ws)
                W_IDLE: begin
                    if (start) begin
                        if (mode == MODE_NORMAL) begin
                            ws       <= W_GO_SRC;
                            cur_src  <= src_base;
                            cur_dst  <= dst_base;
                            chan_en  <= 1'b1;
                            mode_err <= 1'b0;
                            linked_q <= layout_linked;
                        end else begin
                            mode_err <= 1'b1;
                        end
                    end
                end
                W_GO_SRC:   ws <= W_WAIT_SRC;
                W_WAIT_SRC: begin
                    if (fetch_done) begin
                        src_d <= fetch_dscr;
                        ws    <= W_GO_DST;
                    end
                end
                W_GO_DST:   ws <= W_WAIT_DST;
                W_WAIT_DST: begin
                    if (fetch_done) begin
                        dst_d <= fetch_dscr;
                        ws    <= both_empty ? W_DECIDE : W_ISSUE;
                    end
                end
                W_ISSUE: begin
                    if (mv_ack) ws <= W_DECIDE;
                end
                W_DECIDE: begin
                    if (last_any) begin
                        ws      <= W_IDLE;
                        chan_en <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        cur_src <= nxt_src;
                        cur_dst <= nxt_dst;
                        ws      <= pause_any ? W_PAUSED : W_GO_SRC;
                    end
                end
                W_PAUSED: begin
                    if (resume) ws <= W_GO_SRC;
                end
                default: ws <= W_IDLE;
            endcase
        end
    end

    // Accepted start loads the bases and enables the channel (R2).
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && start && mode == MODE_NORMAL) |=>
        (chan_en && state == CH_BUSY && cur_src == $past(src_base) && cur_dst == $past(dst_base)));

    // A mover request stays up until acknowledged (R5).
    assert_mover_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_ack) |=> (mv_req && $stable(src_d) && $stable(dst_d)));

    // No mover request for a pair with nothing to move (R6).
    assert_no_empty_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (src_d.size != '0 || dst_d.size != '0));

    // Done only appears once the channel is idle and disabled (R7).
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!chan_en && state == CH_IDLE && $past(chan_en)));

    // A parked channel issues nothing (R8).
    assert_paused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PAUSED) |-> (!mv_req && !fetch_go));

    // Resume brings a parked channel back to busy (R8).
    assert_resume_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PAUSED && resume) |=> (state == CH_BUSY));

    // Refused mode leaves the channel idle with the error flag set (R10).
    assert_mode_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && start && mode != MODE_NORMAL) |=>
        (mode_err && !chan_en && state == CH_IDLE));

    // Start during a pause moves nothing (R11).
    assert_pause_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PAUSED && start && !resume) |=>
        (state == CH_PAUSED && $stable(cur_src) && $stable(cur_dst)));

endmodule

// File: rtl/sgw_walker.sv
// Module: sgw_walker (top)
// One channel's scatter-gather descriptor walker. A shared fetcher reads the
// source and destination descriptors in turn, and two successor calculators
// follow the chains. The sequencer drives the mover handshake and the channel
// state. Assumes both chains hold equal pair counts and end on the same pair.
module sgw_walker
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic [1:0]        mode,
    input  logic              layout_linked,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic [WORD_W-1:0] fetch_data,
    output logic              mv_req,
    output logic [ADDR_W-1:0] mv_src_addr,
    output logic [LEN_W-1:0]  mv_src_len,
    output logic [ADDR_W-1:0] mv_dst_addr,
    output logic [LEN_W-1:0]  mv_dst_len,
    input  logic              mv_ack,
    output logic              chan_en,
    output logic [1:0]        state,
    output logic              done,
    output logic              mode_err,
    output logic [ADDR_W-1:0] cur_src_dscr,
    output logic [ADDR_W-1:0] cur_dst_dscr
);

    logic              f_go;
    logic [ADDR_W-1:0] f_base;
    logic              f_done;
    dscr_t             f_dscr;
    dscr_t             src_d;
    dscr_t             dst_d;
    logic              linked_q;
    logic [ADDR_W-1:0] nxt_src;
    logic [ADDR_W-1:0] nxt_dst;

    sgw_fetch u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (f_go),
        .base    (f_base),
        .linked  (linked_q),
        .done    (f_done),
        .dscr    (f_dscr),
        .rd_req  (fetch_req),
        .rd_addr (fetch_addr),
        .rd_ack  (fetch_ack),
        .rd_data (fetch_data)
    );

    sgw_nextptr u_next_src (
        .linked     (linked_q),
        .cur        (cur_src_dscr),
        .link_field (src_d.next),
        .nxt        (nxt_src)
    );

    sgw_nextptr u_next_dst (
        .linked     (linked_q),
        .cur        (cur_dst_dscr),
        .link_field (dst_d.next),
        .nxt        (nxt_dst)
    );

    sgw_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .resume        (resume),
        .mode          (mode),
        .layout_linked (layout_linked),
        .src_base      (src_base),
        .dst_base      (dst_base),
        .fetch_go      (f_go),
        .fetch_base    (f_base),
        .fetch_done    (f_done),
        .fetch_dscr    (f_dscr),
        .mv_req        (mv_req),
        .mv_ack        (mv_ack),
        .src_d         (src_d),
        .dst_d         (dst_d),
        .nxt_src       (nxt_src),
        .nxt_dst       (nxt_dst),
        .linked_q      (linked_q),
        .cur_src       (cur_src_dscr),
        .cur_dst       (cur_dst_dscr),
        .chan_en       (chan_en),
        .state         (state),
        .done          (done),
        .mode_err      (mode_err)
    );

    // Mover payload comes straight from the captured pair.
    assign mv_src_addr = src_d.buf_addr;
    assign mv_src_len  = src_d.size;
    assign mv_dst_addr = dst_d.buf_addr;
    assign mv_dst_len  = dst_d.size;

    // Only the three defined state codes appear, matching the enable (R9).
    assert_state_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd3) && (chan_en == (state != CH_IDLE)));

    // Descriptor reads and mover requests never overlap.
    assert_single_port_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && mv_req));

endmodule

// File: tb/sim_sgw_walker.sv
`timescale 1ns/1ps
module sim_sgw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        resume = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        layout_linked = 1'b0;
    logic [63:0] src_base = '0;
    logic [63:0] dst_base = '0;
    logic        fetch_req;
    logic [63:0] fetch_addr;
    logic        fetch_ack;
    logic [63:0] fetch_data;
    logic        mv_req;
    logic [63:0] mv_src_addr;
    logic [31:0] mv_src_len;
    logic [63:0] mv_dst_addr;
    logic [31:0] mv_dst_len;
    logic        mv_ack;
    logic        chan_en;
    logic [1:0]  state;
    logic        done;
    logic        mode_err;
    logic [63:0] cur_src_dscr;
    logic [63:0] cur_dst_dscr;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    sgw_walker u0 (.*);

    // Memory image and transaction logs.
    logic [63:0] mem [longint unsigned];
    logic [63:0] flog[$];
    logic [63:0] m_sa[$];
    logic [63:0] m_da[$];
    logic [31:0] m_sl[$];
    logic [31:0] m_dl[$];

    // Model of the chains for the current trial.
    logic [63:0] sp[8], dp[8], sa[8], da[8];
    logic [31:0] sl[8], dl[8];
    logic        ps[8], pd[8], ls[8], ld[8];
    int          n_pairs;
    bit          lnk;

    function automatic logic [63:0] rdmem(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'hDEAD_BEEF_0BAD_F00D;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, tag, what, act, exp);
    endtask

    // Descriptor memory responder with random latency.
    int f_wait = 0;
    initial begin
        fetch_ack  = 1'b0;
        fetch_data = '0;
        forever begin
            @(negedge clk);
            if (fetch_ack) begin
                fetch_ack = 1'b0;
            end else if (fetch_req) begin
                if (f_wait == 0) begin
                    fetch_ack  = 1'b1;
                    fetch_data = rdmem(fetch_addr);
                    flog.push_back(fetch_addr);
                    f_wait = $urandom % 3;
                end else begin
                    f_wait--;
                end
            end
        end
    end

    // Data mover responder with random latency.
    int m_wait = 0;
    initial begin
        mv_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (mv_ack) begin
                mv_ack = 1'b0;
            end else if (mv_req) begin
                if (m_wait == 0) begin
                    mv_ack = 1'b1;
                    m_sa.push_back(mv_src_addr);
                    m_da.push_back(mv_dst_addr);
                    m_sl.push_back(mv_src_len);
                    m_dl.push_back(mv_dst_len);
                    m_wait = $urandom % 5;
                end else begin
                    m_wait--;
                end
            end
        end
    end

    // Build both chains in memory.
    // kind 0 random, 1 all empty, 2 end marker on dst only, 3 pause everywhere.
    task automatic build(input int t, input bit linked, input int n, input int kind);
        logic [63:0] sb, db, sc, dc;
        n_pairs = n;
        lnk     = linked;
        mem.delete();
        sb = 64'h0001_0000 + 64'(t) * 64'h1000;
        db = 64'h0080_0000 + 64'(t) * 64'h1000;
        for (int i = 0; i < n; i++) begin
            sp[i] = linked ? sb + 64'(((i * 5 + 3) % 8) * 32) : sb + 64'(16 * i);
            dp[i] = linked ? db + 64'(((i * 3 + 5) % 8) * 32) : db + 64'(16 * i);
        end
        for (int i = 0; i < n; i++) begin
            int r;
            sa[i] = {$urandom, $urandom};
            da[i] = {$urandom, $urandom};
            sl[i] = (kind == 1 || $urandom % 4 == 0) ? 32'd0 : ($urandom % 4096) + 1;
            dl[i] = (kind == 1 || $urandom % 4 == 0) ? 32'd0 : ($urandom % 4096) + 1;
            ps[i] = (kind == 3) ? 1'b1 : ($urandom % 4 == 0);
            pd[i] = (kind == 3) ? 1'b0 : ($urandom % 4 == 0);
            r = (kind == 2) ? 1 : int'($urandom % 3);
            ls[i] = (i == n - 1) && (r != 1);
            ld[i] = (i == n - 1) && (r != 0);
            sc = 64'({$urandom} & 32'hFFFF_FFFC) | 64'({ps[i], ls[i]});
            dc = 64'({$urandom} & 32'hFFFF_FFFC) | 64'({pd[i], ld[i]});
            mem[sp[i]]     = sa[i];
            mem[sp[i] + 8] = {sc[31:0], sl[i]};
            mem[dp[i]]     = da[i];
            mem[dp[i] + 8] = {dc[31:0], dl[i]};
            if (linked) begin
                mem[sp[i] + 16] = (i < n - 1) ? sp[i + 1] : {$urandom, $urandom};
                mem[dp[i] + 16] = (i < n - 1) ? dp[i + 1] : {$urandom, $urandom};
                mem[sp[i] + 24] = {$urandom, $urandom};
                mem[dp[i] + 24] = {$urandom, $urandom};
            end
        end
    endtask

    task automatic run_trial();
        int cyc = 0;
        int dones = 0;
        int pcount = 0;
        int pq[$];
        int exp_moves = 0;
        int k = 0;
        int words;
        bit hung = 0;
        logic [63:0] hold_s, hold_d;
        flog.delete(); m_sa.delete(); m_da.delete(); m_sl.delete(); m_dl.delete();
        for (int i = 0; i < n_pairs - 1; i++) if (ps[i] || pd[i]) pq.push_back(i);
        mode = 2'd0;
        layout_linked = lnk;
        src_base = sp[0];
        dst_base = dp[0];
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        layout_linked = ~lnk;
        chk_eq("R2", "state after start", 64'(state), 64'd2);
        chk_eq("R2", "chan_en after start", 64'(chan_en), 64'd1);
        chk_eq("R12", "cur_src at start", cur_src_dscr, sp[0]);
        chk_eq("R12", "cur_dst at start", cur_dst_dscr, dp[0]);
        chk_eq("R10", "mode_err cleared", 64'(mode_err), 64'd0);
        while (dones == 0 && !hung) begin
            @(negedge clk);
            cyc++;
            start = (cyc == 3);
            if (cyc > 6000) hung = 1;
            if (done) dones++;
            if (state == 2'd1) begin
                if (pcount < pq.size()) begin
                    chk_eq("R12", "cur_src while paused", cur_src_dscr, sp[pq[pcount] + 1]);
                    chk_eq("R12", "cur_dst while paused", cur_dst_dscr, dp[pq[pcount] + 1]);
                end else begin
                    chk(0, "R8", "unexpected pause", 64'(pcount), 64'(pq.size()));
                end
                pcount++;
                hold_s = cur_src_dscr;
                hold_d = cur_dst_dscr;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                k = 0;
                repeat (2 + $urandom % 4) begin
                    @(negedge clk);
                    if (fetch_req || mv_req || state != 2'd1) k++;
                end
                chk_eq("R8", "activity while paused", 64'(k), 64'd0);
                chk(cur_src_dscr == hold_s && cur_dst_dscr == hold_d, "R11",
                    "start while paused moved pointers", cur_src_dscr, hold_s);
                resume = 1'b1;
                @(negedge clk);
                resume = 1'b0;
                chk_eq("R8", "state after resume", 64'(state), 64'd2);
            end
        end
        chk(!hung, "R7", "walk never finished", 64'(cyc), 64'd0);
        repeat (3) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk_eq("R7", "done pulse count", 64'(dones), 64'd1);
        chk_eq("R7", "chan_en after end", 64'(chan_en), 64'd0);
        chk_eq("R9", "state after end", 64'(state), 64'd0);
        chk_eq("R8", "pause count", 64'(pcount), 64'(pq.size()));
        // Expected read sequence: source words then destination words per pair.
        words = lnk ? 3 : 2;
        chk_eq(lnk ? "R4" : "R3", "read count", 64'(flog.size()), 64'(2 * words * n_pairs));
        if (flog.size() == 2 * words * n_pairs) begin
            for (int i = 0; i < n_pairs; i++) begin
                for (int w = 0; w < words; w++) begin
                    chk_eq(lnk ? "R4" : "R3", "src read addr", flog[(2 * i) * words + w], sp[i] + 64'(8 * w));
                    chk_eq("R5", "dst read addr", flog[(2 * i + 1) * words + w], dp[i] + 64'(8 * w));
                end
            end
        end
        for (int i = 0; i < n_pairs; i++) if (sl[i] != 0 || dl[i] != 0) exp_moves++;
        chk_eq("R6", "mover request count", 64'(m_sa.size()), 64'(exp_moves));
        if (m_sa.size() == exp_moves) begin
            int j = 0;
            for (int i = 0; i < n_pairs; i++) begin
                if (sl[i] != 0 || dl[i] != 0) begin
                    chk_eq("R5", "mover src addr", m_sa[j], sa[i]);
                    chk_eq("R5", "mover dst addr", m_da[j], da[i]);
                    chk_eq("R5", "mover src len", 64'(m_sl[j]), 64'(sl[i]));
                    chk_eq("R5", "mover dst len", 64'(m_dl[j]), 64'(dl[i]));
                    j++;
                end
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk_eq("R1", "state in reset", 64'(state), 64'd0);
        chk_eq("R1", "chan_en in reset", 64'(chan_en), 64'd0);
        chk_eq("R1", "requests in reset", 64'({fetch_req, mv_req}), 64'd0);
        chk_eq("R1", "done/mode_err in reset", 64'({done, mode_err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: every non-normal mode is refused
        for (int m = 1; m < 4; m++) begin
            mode = 2'(m);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk_eq("R10", "mode_err after refused start", 64'(mode_err), 64'd1);
            chk_eq("R10", "state after refused start", 64'(state), 64'd0);
            @(negedge clk);
            chk_eq("R10", "no fetch after refused start", 64'({fetch_req, chan_en}), 64'd0);
        end

        // R11: resume while idle does nothing
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        @(negedge clk);
        chk_eq("R11", "resume while idle", 64'({state, fetch_req, chan_en}), 64'd0);

        // Directed corner chains.
        build(0, 1'b0, 1, 0); run_trial();
        build(1, 1'b1, 1, 0); run_trial();
        build(2, 1'b0, 4, 1); run_trial();
        build(3, 1'b1, 4, 1); run_trial();
        build(4, 1'b1, 6, 3); run_trial();
        build(5, 1'b0, 5, 3); run_trial();
        build(6, 1'b0, 3, 2); run_trial();
        build(7, 1'b1, 3, 2); run_trial();

        // Random chains.
        for (int t = 8; t < 40; t++) begin
            build(t, 1'($urandom % 2), 1 + int'($urandom % 6), 0);
            run_trial();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule